// File: doc/BRIEF.md
# Constant-Delay Time Slot Interchanger

This block switches byte-wide channels of one time-division stream onto another. A frame stands for 125 µs and holds a fixed number of byte slots. A channel running at N × 64 kbps takes N of those slots. Every input byte is written into a frame store. In the following frame, each output slot sends the byte that its connection entry selects. Because of this, every byte leaves exactly one frame after it arrived, whatever the source and destination slot numbers. All slots of a multi-slot channel therefore stay together and keep their order.

The frame store has two banks. They swap at each frame start: the incoming frame is written to one bank while the previous frame is read from the other. A control port writes connection entries into a shadow map. Each entry holds a source slot, a message flag, an enable flag and a constant byte. The shadow map is copied to the active map at the next frame start. The same port can read back any input slot of the last completed frame.

Top module: `tsi_switch`

## Requirements
- R1: While reset is held, `out_en`, `out_data` and `mon_data` are 0. Both data banks and every connection entry are cleared, so all output slots start disabled.
- R2: A cycle with `frame_sync` high is slot 0. Without it, the slot number rises by one each cycle and wraps to 0 after slot SLOTS-1. The first cycle after reset is slot 0. Every slot-0 cycle swaps the banks, including one forced early by `frame_sync`.
- R3: If output slot d is enabled and not in message mode, with source s, then the cycle after slot d's cycle drives `out_data` with the byte that arrived in slot s of the previous frame, and `out_en` is 1.
- R4: When N input slots are mapped in order onto N output slots, the N bytes of one input frame all leave in the next output frame and keep their original relative order.
- R5: If output slot d is enabled and in message mode, the cycle after slot d carries that entry's constant byte, whatever the input data was.
- R6: If output slot d is disabled, the cycle after slot d shows `out_en` = 0 and `out_data` = 0.
- R7: A connection write (`cm_wr`) changes only the shadow map. The output still follows the old entry until the next slot-0 cycle, and follows the new entry from that cycle on.
- R8: The cycle after `mon_rd`, `mon_data` holds the byte captured in slot `mon_slot` of the most recently completed frame. Without `mon_rd`, `mon_data` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one slot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_sync | input | 1 | Marks the current cycle as slot 0 |
| in_data | input | DW | Input byte of the current slot |
| out_data | output | DW | Switched output byte, one cycle after its slot |
| out_en | output | 1 | Output slot is driven |
| cm_wr | input | 1 | Write a connection entry |
| cm_slot | input | SW | Output slot of the entry |
| cm_src | input | SW | Source input slot |
| cm_msg | input | 1 | Message mode flag |
| cm_oe | input | 1 | Output enable flag |
| cm_byte | input | DW | Constant byte for message mode |
| mon_rd | input | 1 | Read a captured input slot |
| mon_slot | input | SW | Input slot to read |
| mon_data | output | DW | Byte read back, one cycle after `mon_rd` |

## Verification
The byte and the enable for a slot's cycle are registered, so they are due one cycle later. A read-back is also due one cycle after `mon_rd`, and a connection write first shows on the output in the slot-0 cycle that follows it. The bench drives inputs at the falling edge. It updates its own frame banks and its shadow and active maps as it drives each cycle, and compares the registered outputs at the next falling edge. That is exactly one cycle later, which puts every comparison on the cycle in which its result is due.

// File: rtl/tsi_switch.sv
module tsi_switch #(
  parameter int SLOTS = 32,
  parameter int DW    = 8,
  localparam int SW   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_sync,
  input  logic [DW-1:0] in_data,
  output logic [DW-1:0] out_data,
  output logic          out_en,
  input  logic          cm_wr,
  input  logic [SW-1:0] cm_slot,
  input  logic [SW-1:0] cm_src,
  input  logic          cm_msg,
  input  logic          cm_oe,
  input  logic [DW-1:0] cm_byte,
  input  logic          mon_rd,
  input  logic [SW-1:0] mon_slot,
  output logic [DW-1:0] mon_data
);

  localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);

  logic [DW-1:0] mem [2][SLOTS];

  logic [SW-1:0] sh_src  [SLOTS];
  logic          sh_msg  [SLOTS];
  logic          sh_oe   [SLOTS];
  logic [DW-1:0] sh_byte [SLOTS];
  logic [SW-1:0] act_src  [SLOTS];
  logic          act_msg  [SLOTS];
  logic          act_oe   [SLOTS];
  logic [DW-1:0] act_byte [SLOTS];

  logic [SW-1:0] slot_q, cur_slot;
  logic          bank_q, wr_bank, rd_bank, boundary;
  logic [SW-1:0] e_src;
  logic          e_msg, e_oe;
  logic [DW-1:0] e_byte;

  assign cur_slot = frame_sync ? '0 : ((slot_q == LAST) ? '0 : slot_q + 1'b1);
  assign boundary = (cur_slot == '0);
  assign wr_bank  = boundary ? ~bank_q : bank_q;
  assign rd_bank  = ~wr_bank;

  assign e_src  = boundary ? sh_src[cur_slot]  : act_src[cur_slot];
  assign e_msg  = boundary ? sh_msg[cur_slot]  : act_msg[cur_slot];
  assign e_oe   = boundary ? sh_oe[cur_slot]   : act_oe[cur_slot];
  assign e_byte = boundary ? sh_byte[cur_slot] : act_byte[cur_slot];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q   <= LAST;
      bank_q   <= 1'b0;
      out_data <= '0;
      out_en   <= 1'b0;
      mon_data <= '0;
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < SLOTS; i++) mem[b][i] <= '0;
      for (int i = 0; i < SLOTS; i++) begin
        sh_src[i]  <= '0; sh_msg[i]  <= 1'b0; sh_oe[i]  <= 1'b0; sh_byte[i]  <= '0;
        act_src[i] <= '0; act_msg[i] <= 1'b0; act_oe[i] <= 1'b0; act_byte[i] <= '0;
      end
    end else begin
      slot_q <= cur_slot;
      bank_q <= wr_bank;
      mem[wr_bank][cur_slot] <= in_data;
      if (boundary) begin
        for (int i = 0; i < SLOTS; i++) begin
          act_src[i]  <= sh_src[i];
          act_msg[i]  <= sh_msg[i];
          act_oe[i]   <= sh_oe[i];
          act_byte[i] <= sh_byte[i];
        end
      end
      if (cm_wr) begin
        sh_src[cm_slot]  <= cm_src;
        sh_msg[cm_slot]  <= cm_msg;
        sh_oe[cm_slot]   <= cm_oe;
        sh_byte[cm_slot] <= cm_byte;
      end
      out_en   <= e_oe;
      out_data <= !e_oe ? '0 : (e_msg ? e_byte : mem[rd_bank][e_src]);
      if (mon_rd) mon_data <= mem[rd_bank][mon_slot];
    end
  end

  // R2
  sync_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync |=> (slot_q == '0));

  // R2
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q <= LAST);

  // R2
  bank_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync |=> (bank_q != $past(bank_q)));

  // R6
  quiet_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> (out_data == '0));

  // R8
  mon_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_rd |=> $stable(mon_data));

endmodule

// File: tb/tsi_switch_bench.sv
`timescale 1ns/1ps
module tsi_switch_bench;
  localparam int S  = 32;
  localparam int DW = 8;
  localparam int SW = $clog2(S);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, frame_sync, cm_wr, cm_msg, cm_oe, mon_rd, out_en;
  logic [DW-1:0] in_data, out_data, cm_byte, mon_data;
  logic [SW-1:0] cm_slot, cm_src, mon_slot;

  tsi_switch #(.SLOTS(S), .DW(DW)) u_tsi_switch (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .in_data(in_data),
    .out_data(out_data), .out_en(out_en), .cm_wr(cm_wr), .cm_slot(cm_slot),
    .cm_src(cm_src), .cm_msg(cm_msg), .cm_oe(cm_oe), .cm_byte(cm_byte),
    .mon_rd(mon_rd), .mon_slot(mon_slot), .mon_data(mon_data));

  int n_run = 0, n_fail = 0;
  int bslot = S - 1;
  bit wb = 1'b0;
  logic [DW-1:0] bm [2][S];
  int sh_src [S], act_src [S];
  bit sh_msg [S], act_msg [S], sh_oe [S], act_oe [S];
  logic [DW-1:0] sh_byte [S], act_byte [S];
  logic [DW-1:0] exp_d = '0, exp_r = '0;
  bit exp_e = 1'b0, have_exp = 1'b0;
  string tag = "R1", force_tag = "";

  task automatic chk(bit ok, string r, string what, int act, int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, expv);
    end
  endtask

  task automatic cycle(bit sync, logic [DW-1:0] din, bit wr, int wa, int wsrc,
                       bit wmsg, bit woe, logic [DW-1:0] wbyte, bit rd, int ra);
    int cur;
    bit pend;
    @(negedge clk);
    if (have_exp) begin
      chk(out_en === exp_e, tag, "out_en", int'(out_en), int'(exp_e));
      chk(out_data === exp_d, tag, "out_data", int'(out_data), int'(exp_d));
      chk(mon_data === exp_r, "R8", "mon_data", int'(mon_data), int'(exp_r));
    end
    frame_sync = sync; in_data = din; cm_wr = wr; cm_slot = SW'(wa);
    cm_src = SW'(wsrc); cm_msg = wmsg; cm_oe = woe; cm_byte = wbyte;
    mon_rd = rd; mon_slot = SW'(ra);
    cur = sync ? 0 : ((bslot == S - 1) ? 0 : bslot + 1);
    if (cur == 0) begin
      wb = ~wb;
      for (int i = 0; i < S; i++) begin
        act_src[i] = sh_src[i]; act_msg[i] = sh_msg[i];
        act_oe[i] = sh_oe[i]; act_byte[i] = sh_byte[i];
      end
    end
    pend = (sh_src[cur] != act_src[cur]) || (sh_msg[cur] != act_msg[cur]) ||
           (sh_oe[cur] != act_oe[cur]) || (sh_byte[cur] != act_byte[cur]);
    exp_e = act_oe[cur];
    exp_d = !act_oe[cur] ? '0 : (act_msg[cur] ? act_byte[cur] : bm[~wb][act_src[cur]]);
    if (force_tag != "") tag = force_tag;
    else if (sync && bslot != S - 1) tag = "R2";
    else if (pend) tag = "R7";
    else if (!act_oe[cur]) tag = "R6";
    else if (act_msg[cur]) tag = "R5";
    else tag = "R3";
    bm[wb][cur] = din;
    if (rd) exp_r = bm[~wb][ra];
    if (wr) begin
      sh_src[wa] = wsrc; sh_msg[wa] = wmsg; sh_oe[wa] = woe; sh_byte[wa] = wbyte;
    end
    bslot = cur;
    have_exp = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int unsigned seed;
    bit sy;
    seed = $urandom(32'd4242);
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < S; i++) bm[b][i] = '0;
    for (int i = 0; i < S; i++) begin
      sh_src[i] = 0; act_src[i] = 0; sh_msg[i] = 0; act_msg[i] = 0;
      sh_oe[i] = 0; act_oe[i] = 0; sh_byte[i] = '0; act_byte[i] = '0;
    end
    rst_n = 1'b0; frame_sync = 0; in_data = '0; cm_wr = 0; cm_slot = '0;
    cm_src = '0; cm_msg = 0; cm_oe = 0; cm_byte = '0; mon_rd = 0; mon_slot = '0;
    repeat (3) @(negedge clk);
    chk(out_en === 1'b0, "R1", "out_en", int'(out_en), 0);
    chk(out_data === '0, "R1", "out_data", int'(out_data), 0);
    chk(mon_data === '0, "R1", "mon_data", int'(mon_data), 0);
    rst_n = 1'b1;

    // reversed map written during frame 0; slot 7 message, slot 9 disabled
    for (int i = 0; i < S; i++)
      cycle(i == 0, 8'($urandom), 1, i, S - 1 - i, i == 7, i != 9, 8'h5A, 0, 0);
    for (int f = 0; f < 2; f++)
      for (int i = 0; i < S; i++)
        cycle(i == 0, 8'($urandom), 0, 0, 0, 0, 0, '0, 1, (i * 7) % S);

    // R4: channel in input slots 20..23 moved to output slots 2..5
    for (int i = 0; i < S; i++)
      cycle(i == 0, 8'(8'h40 + i), (i < 4), 2 + i, 20 + i, 0, 1, '0, 0, 0);
    force_tag = "R4";
    for (int i = 0; i < S; i++)
      cycle(i == 0, 8'(8'h80 + i), 0, 0, 0, 0, 0, '0, 0, 0);
    force_tag = "";

    // random traffic, map changes, read-backs and early frame starts (R2, R7, R8)
    for (int f = 0; f < 36; f++)
      for (int i = 0; i < S; i++) begin
        sy = (bslot == S - 1) ? bit'($urandom % 2) : 1'b0;
        if (f % 5 == 3 && i == 17) sy = 1'b1;
        cycle(sy, 8'($urandom), ($urandom % 8) == 0, int'($urandom % S),
              int'($urandom % S), ($urandom % 4) == 0, ($urandom % 5) != 0,
              8'($urandom), ($urandom % 6) == 0, int'($urandom % S));
      end
    cycle(0, '0, 0, 0, 0, 0, 0, '0, 0, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule